// File: doc/BRIEF.md
# Twelve-Bit Free-Running Timer with Snapshot Read

The block is a 12-bit up-counter that runs freely. It advances by one on every cycle in which the one-microsecond tick enable is high. Software reads the count through two byte-wide, read-only addresses. A read of the low byte returns count bits 7:0. In the same access, that read copies count bits 11:8 into a holding register. A later read of the high byte returns the held nibble and never the live count. The two bytes therefore always form one consistent 12-bit value, however many cycles separate the two reads.

The counter also drives two periodic interrupt pulses. The fast pulse comes every 128 ticks, which is 128 µs. The slow pulse comes every 1024 ticks, which is 1.024 ms. Each pulse lasts one clock. They go to an interrupt controller outside this block.

Read data is registered. A read sampled at one clock edge shows its result on `rd_data_o` for the following cycle. A small state machine records which kind of access was sampled at the last edge:

- `RD_IDLE`: no read was sampled.
- `RD_LOW`: a low-byte read was sampled.
- `RD_HIGH`: a high-byte read was sampled.
- `RD_MISS`: a read to any other address was sampled.

At every edge the machine moves from its present state to one of these states:

- to `RD_IDLE` when `rd_en_i` is low;
- to `RD_LOW` when the address is 0x24;
- to `RD_HIGH` when the address is 0x25;
- to `RD_MISS` for any other address.

Every state can reach every state. The output process selects the read data from the present state.

Top module: `tmr12_split_read`

## Requirements
- R1: After reset the counter and the holding register are 0, `rd_data_o` is 0 and both interrupt outputs are low.
- R2: The counter increments by exactly one at each clock edge where `tick_i` is high, and holds its value at every other edge.
- R3: The counter wraps from 0xFFF to 0x000 on a tick and keeps counting.
- R4: A read of address 0x24 sampled at an edge makes `rd_data_o`, for the next cycle, equal to count bits 7:0 as they were before that edge.
- R5: A read of address 0x24 loads count bits 11:8 into the holding register at the same edge. No other access changes the holding register.
- R6: A read of address 0x25 makes `rd_data_o`, for the next cycle, equal to the holding register in bits 3:0, with bits 7:4 reading 0. The live count does not appear in it.
- R7: A high-byte read with no earlier low-byte read returns the last held value, which is 0 after reset.
- R8: `irq_fast_o` is high for exactly the one cycle after a tick edge at which count bits 6:0 go from 0x7F to 0.
- R9: `irq_slow_o` is high for exactly the one cycle after a tick edge at which count bits 9:0 go from 0x3FF to 0.
- R10: When no read, or a read to any address other than 0x24 and 0x25, is sampled at an edge, `rd_data_o` is 0 for the next cycle.
- R11: Reads of either address do not disturb the counter.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | One-microsecond count enable |
| rd_en_i | input | 1 | Read strobe |
| rd_addr_i | input | 8 | Read address |
| rd_data_o | output | 8 | Registered read data for the access sampled at the previous edge |
| irq_fast_o | output | 1 | One-clock pulse every 128 ticks |
| irq_slow_o | output | 1 | One-clock pulse every 1024 ticks |

## Verification
Most faults in this block show up at the ports within a cycle or two.

- A miscounting or stuck counter changes the very next low-byte read. It also shifts the cycle in which either interrupt pulse appears, so the pulse arrives early, late or not at all within 128 ticks.
- A holding register that follows the live count, or that an access other than a low read updates, shows up at the first high read made after the count crosses a 256 boundary. The directed wrap sequence sets this case up on purpose.
- A wrong read state shows up in the cycle after the access. The data is then nonzero after an idle cycle, or it comes from the wrong source.

// File: rtl/tmr12_pkg.sv
package tmr12_pkg;

    // Kind of read access sampled at the most recent clock edge.
    typedef enum logic [1:0] {
        RD_IDLE = 2'd0,
        RD_LOW  = 2'd1,
        RD_HIGH = 2'd2,
        RD_MISS = 2'd3
    } rd_state_e;

    // Interrupt index 0 is the fast period, index 1 is the slow period.
    localparam int IRQ_N = 2;

endpackage

// File: rtl/tmr12_count.sv
module tmr12_count
    import tmr12_pkg::*;
#(
    parameter int CNT_W     = 12,
    parameter int FAST_BITS = 7,
    parameter int SLOW_BITS = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    output logic [CNT_W-1:0] count_o,
    output logic [IRQ_N-1:0] irq_o
);

    logic [CNT_W-1:0] count_q;

    // Free-running count; wraps naturally at the full width.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (tick_i) begin
            count_q <= count_q + 1'b1;
        end
    end

    assign count_o = count_q;

    // One pulse generator per period.
    // Each pulse fires when the low SPAN bits are about to roll over to zero.
    for (genvar g = 0; g < IRQ_N; g++) begin : g_irq
        localparam int SPAN = (g == 0) ? FAST_BITS : SLOW_BITS;

        logic roll;
        logic pulse_q;

        assign roll = tick_i && (&count_q[SPAN-1:0]);

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pulse_q <= 1'b0;
            end else begin
                pulse_q <= roll;
            end
        end

        assign irq_o[g] = pulse_q;
    end

endmodule

// File: rtl/tmr12_rdport.sv
module tmr12_rdport
    import tmr12_pkg::*;
#(
    parameter int                CNT_W   = 12,
    parameter int                DATA_W  = 8,
    parameter int                ADDR_W  = 8,
    parameter logic [ADDR_W-1:0] ADDR_LO = 8'h24,
    parameter logic [ADDR_W-1:0] ADDR_HI = 8'h25
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    input  logic [CNT_W-1:0]  count_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic [CNT_W-DATA_W-1:0] hold_o
);

    localparam int HOLD_W = CNT_W - DATA_W;

    rd_state_e          state_q;
    rd_state_e          state_d;
    logic [DATA_W-1:0]  lo_q;
    logic [HOLD_W-1:0]  hold_q;

    // Next state: the kind of access sampled at this edge.
    always_comb begin
        if (!rd_en_i) begin
            state_d = RD_IDLE;
        end else if (rd_addr_i == ADDR_LO) begin
            state_d = RD_LOW;
        end else if (rd_addr_i == ADDR_HI) begin
            state_d = RD_HIGH;
        end else begin
            state_d = RD_MISS;
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RD_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // A low-byte read captures both the low byte and the upper nibble.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q   <= '0;
            hold_q <= '0;
        end else if (state_d == RD_LOW) begin
            lo_q   <= count_i[DATA_W-1:0];
            hold_q <= count_i[CNT_W-1:DATA_W];
        end
    end

    // Output selection from the present state.
    always_comb begin
        unique case (state_q)
            RD_IDLE: rd_data_o = '0;
            RD_LOW:  rd_data_o = lo_q;
            RD_HIGH: rd_data_o = DATA_W'(hold_q);
            RD_MISS: rd_data_o = '0;
            default: rd_data_o = '0;
        endcase
    end

    assign hold_o = hold_q;

endmodule

// File: rtl/tmr12_split_read.sv
module tmr12_split_read
    import tmr12_pkg::*;
#(
    parameter int                CNT_W     = 12,
    parameter int                DATA_W    = 8,
    parameter int                ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] ADDR_LO   = 8'h24,
    parameter logic [ADDR_W-1:0] ADDR_HI   = 8'h25,
    parameter int                FAST_BITS = 7,
    parameter int                SLOW_BITS = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              rd_en_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              irq_fast_o,
    output logic              irq_slow_o
);

    localparam int HOLD_W = CNT_W - DATA_W;

    logic [CNT_W-1:0]  count_w;
    logic [HOLD_W-1:0] hold_w;
    logic [IRQ_N-1:0]  irq_w;

    tmr12_count #(
        .CNT_W     (CNT_W),
        .FAST_BITS (FAST_BITS),
        .SLOW_BITS (SLOW_BITS)
    ) u_count (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_i  (tick_i),
        .count_o (count_w),
        .irq_o   (irq_w)
    );

    tmr12_rdport #(
        .CNT_W   (CNT_W),
        .DATA_W  (DATA_W),
        .ADDR_W  (ADDR_W),
        .ADDR_LO (ADDR_LO),
        .ADDR_HI (ADDR_HI)
    ) u_rdport (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_en_i   (rd_en_i),
        .rd_addr_i (rd_addr_i),
        .count_i   (count_w),
        .rd_data_o (rd_data_o),
        .hold_o    (hold_w)
    );

    assign irq_fast_o = irq_w[0];
    assign irq_slow_o = irq_w[1];

endmodule

// File: rtl/tmr12_checker.sv
module tmr12_checker #(
    parameter int                CNT_W     = 12,
    parameter int                DATA_W    = 8,
    parameter int                ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] ADDR_LO   = 8'h24,
    parameter logic [ADDR_W-1:0] ADDR_HI   = 8'h25,
    parameter int                FAST_BITS = 7
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    tick_i,
    input logic                    rd_en_i,
    input logic [ADDR_W-1:0]       rd_addr_i,
    input logic [DATA_W-1:0]       rd_data_o,
    input logic                    irq_fast_o,
    input logic                    irq_slow_o,
    input logic [CNT_W-1:0]        count_w,
    input logic [CNT_W-DATA_W-1:0] hold_w
);

    localparam int HOLD_W = CNT_W - DATA_W;

    logic lo_rd;
    logic hi_rd;

    assign lo_rd = rd_en_i && (rd_addr_i == ADDR_LO);
    assign hi_rd = rd_en_i && (rd_addr_i == ADDR_HI);

    // R2
    p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_i |=> $stable(count_w));

    // R2, R3
    p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tick_i |=> count_w == CNT_W'($past(count_w) + 1'b1));

    // R5
    p_capture_r5: assert property (@(posedge clk) disable iff (!rst_n)
        lo_rd |=> hold_w == $past(count_w[CNT_W-1:DATA_W]));

    // R5
    p_hold_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !lo_rd |=> $stable(hold_w));

    // R6
    p_reserved_r6: assert property (@(posedge clk) disable iff (!rst_n)
        hi_rd |=> rd_data_o[DATA_W-1:HOLD_W] == '0);

    // R8
    p_fast_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_fast_o |-> (count_w[FAST_BITS-1:0] == '0) && $past(tick_i));

    // R9
    p_slow_in_fast_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_slow_o |-> irq_fast_o);

    // R10
    p_idle_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en_i |=> rd_data_o == '0);

endmodule

bind tmr12_split_read tmr12_checker #(
    .CNT_W     (CNT_W),
    .DATA_W    (DATA_W),
    .ADDR_W    (ADDR_W),
    .ADDR_LO   (ADDR_LO),
    .ADDR_HI   (ADDR_HI),
    .FAST_BITS (FAST_BITS)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_i     (tick_i),
    .rd_en_i    (rd_en_i),
    .rd_addr_i  (rd_addr_i),
    .rd_data_o  (rd_data_o),
    .irq_fast_o (irq_fast_o),
    .irq_slow_o (irq_slow_o),
    .count_w    (count_w),
    .hold_w     (hold_w)
);

// File: tb/tmr12_split_read_bench.sv
module tmr12_split_read_bench;

    localparam logic [7:0] A_LO = 8'h24;
    localparam logic [7:0] A_HI = 8'h25;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_i = 1'b0;
    logic       rd_en_i = 1'b0;
    logic [7:0] rd_addr_i = 8'h00;
    logic [7:0] rd_data_o;
    logic       irq_fast_o;
    logic       irq_slow_o;

    int checks = 0;
    int errors = 0;

    // Bench-side model of the counter and the holding register.
    logic [11:0] m_cnt = 12'h000;
    logic [3:0]  m_hold = 4'h0;

    always #2 clk = ~clk;

    tmr12_split_read u_tmr12_split_read (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (tick_i),
        .rd_en_i    (rd_en_i),
        .rd_addr_i  (rd_addr_i),
        .rd_data_o  (rd_data_o),
        .irq_fast_o (irq_fast_o),
        .irq_slow_o (irq_slow_o)
    );

    // Read data expected from the requirements (R4, R6, R10).
    function automatic logic [7:0] exp_read(input logic r, input logic [7:0] a,
                                            input logic [11:0] c, input logic [3:0] h);
        if (r && a == A_LO) return c[7:0];
        if (r && a == A_HI) return {4'h0, h};
        return 8'h00;
    endfunction

    task automatic check(input string tag, input string what,
                         input logic [11:0] act, input logic [11:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // Called at a negedge: drive one access, let one edge pass, check at the next negedge.
    task automatic step(input logic t, input logic r, input logic [7:0] a, input string tag);
        logic [7:0] e_rd;
        logic       e_fast;
        logic       e_slow;
        string      rtag;
        tick_i    = t;
        rd_en_i   = r;
        rd_addr_i = a;
        e_rd   = exp_read(r, a, m_cnt, m_hold);
        e_fast = t && (m_cnt[6:0] == 7'h7F);
        e_slow = t && (m_cnt[9:0] == 10'h3FF);
        if (r && a == A_LO) m_hold = m_cnt[11:8];
        if (t) m_cnt = m_cnt + 12'h001;
        if (tag != "") rtag = tag;
        else if (r && a == A_LO) rtag = "R4";
        else if (r && a == A_HI) rtag = "R6";
        else rtag = "R10";
        @(negedge clk);
        check(rtag, "rd_data", {4'h0, rd_data_o}, {4'h0, e_rd});
        check("R8", "irq_fast", {11'h0, irq_fast_o}, {11'h0, e_fast});
        check("R9", "irq_slow", {11'h0, irq_slow_o}, {11'h0, e_slow});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual running expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state at the ports.
        check("R1", "rd_data", {4'h0, rd_data_o}, 12'h000);
        check("R1", "irq_fast", {11'h0, irq_fast_o}, 12'h000);
        check("R1", "irq_slow", {11'h0, irq_slow_o}, 12'h000);

        // R7: high read before any low read returns the reset value of the hold.
        step(1'b0, 1'b1, A_HI, "R7");
        step(1'b0, 1'b1, A_LO, "R1");

        // R2: five ticks, idle cycles, then a read shows exactly five.
        for (int i = 0; i < 5; i++) step(1'b1, 1'b0, 8'h00, "R2");
        for (int i = 0; i < 3; i++) step(1'b0, 1'b0, 8'h00, "R2");
        step(1'b0, 1'b1, A_LO, "R2");
        // R11: back-to-back reads leave the count unchanged.
        step(1'b0, 1'b1, A_LO, "R11");
        step(1'b0, 1'b1, A_HI, "R6");
        // R10: reads to other addresses return zero.
        step(1'b0, 1'b1, 8'h26, "R10");
        step(1'b0, 1'b1, 8'h00, "R10");

        // R3: run up to the top of the range, then wrap.
        while (m_cnt != 12'hFFF) step(1'b1, 1'b0, 8'h00, "");
        step(1'b0, 1'b1, A_LO, "R3");
        step(1'b0, 1'b1, A_HI, "R3");
        step(1'b1, 1'b0, 8'h00, "R3");
        step(1'b0, 1'b1, A_LO, "R3");
        step(1'b0, 1'b1, A_HI, "R3");

        // R5, R6: the hold does not follow the live count.
        for (int i = 0; i < 300; i++) step(1'b1, (i % 7) == 3, A_HI, "R6");
        step(1'b0, 1'b1, A_HI, "R5");
        step(1'b1, 1'b1, A_LO, "R5");
        step(1'b1, 1'b1, A_HI, "R5");

        // Random mix of ticks and accesses.
        for (int i = 0; i < 6000; i++) begin
            logic       t;
            logic       r;
            logic [7:0] a;
            int         pick;
            t    = ($urandom % 4) != 0;
            r    = ($urandom % 3) == 0;
            pick = $urandom % 5;
            if (pick < 2) a = A_LO;
            else if (pick < 4) a = A_HI;
            else a = 8'($urandom);
            step(t, r, a, "");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule